// File: doc/BRIEF.md
# Codec Control Register File with Sticky Software Reset

This block holds the two control registers of a voice codec and turns their contents into control signals for the rest of the device. A host reaches the registers through a plain port: an address, an 8-bit write word, a write strobe and a combinational read word. One register holds the software-reset bit, the two power-down bits, the companding-law select and a mode bit. The other holds the 3-bit serial bit-rate select and the receive and transmit gain codes.

The software-reset bit is sticky. Once set, it stays set until the host writes it back to 0 or the power-on reset pin asserts. While it is set, the other bits of its register are held at zero and the second register is held at its default. The write that clears the bit loads nothing else, so the host needs a second write to configure the register. Because no single write both leaves reset and applies a new configuration, the two cannot race.

The power-on reset pin `por_n` is active low. It takes effect at once when it goes low and is released on a clock edge. While it is low, every write is ignored and the block reports full power-down.

Top module: `mfc_ctrl_regs`

## Requirements
- R1: Register CTL_A is at address 03h. Its bit layout is: bit0 software reset, bit1 filter power-down, bit2 converter power-down, bit3 law select, bit4 mode, bits 7:5 always read 0. Register CTL_B is at address 04h. Its bit layout is: bits 2:0 clock select, bits 4:3 receive gain code, bits 6:5 transmit gain code, bit7 always reads 0. A read returns the current contents.
- R2: A read of any address other than 03h or 04h returns 00h. A write to such an address changes neither register.
- R3: After power-on reset, CTL_A reads 00h and CTL_B reads 44h. The outputs then show μ-law (alaw_sel=0), serial mode (aux_mode=0), receive gain code 0 (0 dB), transmit gain code 2 (6 dB), clock select 4 (2048 kb/s) and full_pd=0.
- R4: When CTL_A is written with bit0=1, sw_rst becomes 1 on the next clock edge, whatever the other written bits are. CTL_A then reads 01h and CTL_B returns to 44h.
- R5: While sw_rst is 1, a write to CTL_A with bit0=1 leaves CTL_A at 01h. A write to CTL_B is ignored and CTL_B reads 44h.
- R6: While sw_rst is 1, a write to CTL_A with bit0=0 clears sw_rst but leaves bits 4:1 at 0. A second write with bit0=0 then loads bits 4:1.
- R7: full_pd is 1 exactly when CTL_A bits 1 and 2 are both 1, or when por_n is low.
- R8: Driving por_n low restores every default at once, without waiting for a clock edge. Writes made while por_n is low have no effect.
- R9: The outputs alaw_sel, aux_mode, clk_sel, rx_gain and tx_gain always equal CTL_A bit3, CTL_A bit4, CTL_B bits 2:0, CTL_B bits 4:3 and CTL_B bits 6:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asserts asynchronously |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata | output | 8 | Read data for addr, combinational |
| sw_rst | output | 1 | Sticky software reset state |
| alaw_sel | output | 1 | 1 selects A-law, 0 selects μ-law |
| aux_mode | output | 1 | Interface mode bit, 0 selects serial mode |
| rx_gain | output | 2 | Receive gain code |
| tx_gain | output | 2 | Transmit gain code |
| clk_sel | output | 3 | Serial bit-rate select |
| full_pd | output | 1 | Full power-down flag |

## Verification
The bench writes all 256 values to CTL_B and, with software reset clear, all 256 values to CTL_A. After each write it compares the readback and the decoded outputs with masks and bit fields computed in the bench. This shows whether each field reaches the right output and whether a write with bit0 set wipes the other bits. A second sweep repeats every reset-setting CTL_A value and every CTL_B value while sw_rst is held, which separates a sticky design from one that drops out of reset or takes writes. The remaining patterns are:
- a write to every unmapped address;
- the two-write exit from reset;
- a mid-run power-on reset applied during an attempted write.

Together they cover read decoding and the asynchronous return to the defaults.

// File: rtl/mfc_ctrl_regs.sv
module mfc_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTLA_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] CTLB_ADDR = 'h04,
  parameter logic [2:0] CSEL_DFLT = 3'd4,
  parameter logic [1:0] RXG_DFLT  = 2'd0,
  parameter logic [1:0] TXG_DFLT  = 2'd2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              we,
  output logic [7:0]        rdata,
  output logic              sw_rst,
  output logic              alaw_sel,
  output logic              aux_mode,
  output logic [1:0]        rx_gain,
  output logic [1:0]        tx_gain,
  output logic [2:0]        clk_sel,
  output logic              full_pd
);
  localparam logic [7:0] CTLB_DFLT = {1'b0, TXG_DFLT, RXG_DFLT, CSEL_DFLT};

  logic       rst_q;
  logic [3:0] a_q;
  logic [6:0] b_q;

  wire hit_a = we && (addr == CTLA_ADDR);
  wire hit_b = we && (addr == CTLB_ADDR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b0;
      a_q   <= '0;
      b_q   <= CTLB_DFLT[6:0];
    end else begin
      if (hit_a) begin
        rst_q <= wdata[0];
        if (!rst_q) a_q <= wdata[0] ? 4'd0 : wdata[4:1];
      end
      if (rst_q || (hit_a && wdata[0])) b_q <= CTLB_DFLT[6:0];
      else if (hit_b)                   b_q <= wdata[6:0];
    end
  end

  always_comb begin
    if (addr == CTLA_ADDR)      rdata = {3'b000, a_q, rst_q};
    else if (addr == CTLB_ADDR) rdata = {1'b0, b_q};
    else                        rdata = 8'h00;
  end

  assign sw_rst   = rst_q;
  assign alaw_sel = a_q[2];
  assign aux_mode = a_q[3];
  assign clk_sel  = b_q[2:0];
  assign rx_gain  = b_q[4:3];
  assign tx_gain  = b_q[6:5];
  assign full_pd  = !por_n || (a_q[0] && a_q[1]);
endmodule

module mfc_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTLA_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] CTLB_ADDR = 'h04,
  parameter logic [2:0] CSEL_DFLT = 3'd4,
  parameter logic [1:0] RXG_DFLT  = 2'd0,
  parameter logic [1:0] TXG_DFLT  = 2'd2
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              we,
  input logic [7:0]        rdata,
  input logic              sw_rst,
  input logic              alaw_sel,
  input logic              aux_mode,
  input logic [1:0]        rx_gain,
  input logic [1:0]        tx_gain,
  input logic [2:0]        clk_sel,
  input logic              full_pd
);
  wire clr_wr = we && addr == CTLA_ADDR && !wdata[0];

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (addr != CTLA_ADDR && addr != CTLB_ADDR) |-> rdata == 8'h00);
  // R4
  rst_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (we && addr == CTLA_ADDR && wdata[0]) |=> sw_rst && !alaw_sel && !aux_mode && !full_pd);
  // R5
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst && !clr_wr) |=> sw_rst);
  // R5
  ctlb_held_chk: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> clk_sel == CSEL_DFLT && rx_gain == RXG_DFLT && tx_gain == TXG_DFLT);
  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst && clr_wr) |=> !sw_rst && !alaw_sel && !aux_mode && !full_pd);
  // R7
  pd_both_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sw_rst && we && addr == CTLA_ADDR && wdata[2:0] == 3'b110) |=> full_pd);
endmodule

bind mfc_ctrl_regs mfc_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .CTLA_ADDR(CTLA_ADDR), .CTLB_ADDR(CTLB_ADDR),
  .CSEL_DFLT(CSEL_DFLT), .RXG_DFLT(RXG_DFLT), .TXG_DFLT(TXG_DFLT)
) u_chk (.*);

// File: tb/mfc_ctrl_regs_bench.sv
module mfc_ctrl_regs_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, por_n = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic sw_rst, alaw_sel, aux_mode, full_pd;
  logic [1:0] rx_gain, tx_gain;
  logic [2:0] clk_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  mfc_ctrl_regs u_mfc_ctrl_regs (
    .clk(clk), .por_n(por_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .sw_rst(sw_rst), .alaw_sel(alaw_sel), .aux_mode(aux_mode),
    .rx_gain(rx_gain), .tx_gain(tx_gain), .clk_sel(clk_sel), .full_pd(full_pd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic chk_dflt(input string tag);
    rd(tag, 8'h03, 8'h00);
    rd(tag, 8'h04, 8'h44);
    chk(tag, {alaw_sel, aux_mode, rx_gain, tx_gain, clk_sel, full_pd},
        {1'b0, 1'b0, 2'd0, 2'd2, 3'd4, 1'b0});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R7 full_pd in por", full_pd, 1);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk_dflt("R3 defaults");

    // R1 R9: CTL_B sweep
    for (int v = 0; v < 256; v++) begin
      wr(8'h04, v[7:0]);
      rd("R1 ctlb readback", 8'h04, v[7:0] & 8'h7F);
      chk("R9 ctlb fields", {tx_gain, rx_gain, clk_sel}, v[6:0]);
    end

    // R1 R4 R7 R9: CTL_A sweep with reset clear
    for (int v = 0; v < 256; v++) begin
      if (sw_rst) wr(8'h03, 8'h00);
      wr(8'h04, 8'h1B);
      wr(8'h03, v[7:0]);
      if (v[0]) begin
        rd("R4 ctla reset write", 8'h03, 8'h01);
        rd("R4 ctlb to default", 8'h04, 8'h44);
        chk("R4 sw_rst set", sw_rst, 1);
      end else begin
        rd("R1 ctla readback", 8'h03, v[7:0] & 8'h1E);
        chk("R9 ctla fields", {aux_mode, alaw_sel}, v[4:3]);
        chk("R7 full_pd", full_pd, v[1] & v[2]);
        rd("R1 ctlb kept", 8'h04, 8'h1B);
      end
    end

    // R5: sticky sweep
    wr(8'h03, 8'h01);
    for (int v = 0; v < 256; v++) begin
      if (v[0]) begin
        wr(8'h03, v[7:0]);
        rd("R5 ctla held", 8'h03, 8'h01);
      end
      wr(8'h04, v[7:0]);
      rd("R5 ctlb held", 8'h04, 8'h44);
    end
    chk("R5 still in reset", sw_rst, 1);

    // R6: two-write exit
    wr(8'h03, 8'h1E);
    rd("R6 first write clears only", 8'h03, 8'h00);
    chk("R6 full_pd after clear", full_pd, 0);
    wr(8'h03, 8'h1E);
    rd("R6 second write loads", 8'h03, 8'h1E);
    chk("R7 full_pd both set", full_pd, 1);
    wr(8'h03, 8'h0A);
    chk("R7 one pd bit", full_pd, 0);

    // R2: unmapped addresses
    wr(8'h04, 8'h2D);
    for (int a = 0; a < 256; a++) begin
      if (a != 3 && a != 4) begin
        wr(a[7:0], 8'hFF);
        rd("R2 unmapped read", a[7:0], 8'h00);
      end
    end
    rd("R2 ctla untouched", 8'h03, 8'h0A);
    rd("R2 ctlb untouched", 8'h04, 8'h2D);

    // R8: async power-on reset, write during reset
    @(negedge clk);
    addr = 8'h04; wdata = 8'h11; we = 1'b1;
    #1 por_n = 1'b0;
    #1;
    chk("R8 async ctlb", rdata, 8'h44);
    chk("R8 full_pd", full_pd, 1);
    @(negedge clk);
    addr = 8'h03; wdata = 8'h0C;
    @(negedge clk);
    we = 1'b0; por_n = 1'b1;
    @(negedge clk);
    chk_dflt("R8 writes ignored in por");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule